// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block observes the clock and data lines of a two-wire open-drain bus and turns their edges into bus status for a local master that shares the bus with other masters. Both lines pass through a synchronizer. Edge detection then recognises Start and Stop conditions. Two sticky status bits record which of the two conditions came last, and a bus-free indication is derived from them so that firmware can decide when it may take the bus.

An interrupt flag is set on every Start, on every Stop and on each byte-complete pulse from an external shift register. The flag holds until software clears it. Because it is set on a Stop, a master that is waiting on a busy bus is told when the bus becomes free.

The local master asks for a line to be pulled low through a drive-enable input. The block passes these requests through as open-drain output enables. While the master releases SDA, it compares the level on the bus with the expected high level at every rising edge of SCL. If it sees SDA low, the master has lost arbitration. The block then records whether the loss came in the address byte or in a data byte, and it forces both lines released until the next Stop.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset, and on any cycle after `en_i` has been low, `start_o` and `stop_o` are 0 and `bus_free_o` is 1. While `en_i` is low, no line edge or byte pulse changes any status.
- R2: SDA falling while SCL is high is a Start. It sets `start_o` to 1, clears `stop_o` and drops `bus_free_o`. The change shows at the outputs three clock edges after the line changes.
- R3: SDA rising while SCL is high is a Stop. It sets `stop_o` to 1, clears `start_o` and raises `bus_free_o`. The latency is the same as for a Start.
- R4: A Start with no Stop before it (a repeated Start) keeps `start_o` at 1 and `bus_free_o` at 0. It also returns stage tracking to the address byte.
- R5: SDA changing while SCL is low is neither a Start nor a Stop, and it leaves `start_o`, `stop_o` and `irq_flag_o` unchanged.
- R6: `irq_flag_o` is set by a Start, by a Stop, and by a one-cycle `byte_done_i` pulse. It holds until `irq_clr_i` is high, and a set event in the same cycle as a clear takes priority. `irq_o` equals `irq_flag_o` AND `irq_en_i`, so a Stop seen while the bus is busy raises `irq_o` when `irq_en_i` is 1.
- R7: `scl_oe_o` is 1 only when `scl_drv_i` is 1, `en_i` is 1 and there is no arbitration loss. The same rule applies to `sda_oe_o` with `sda_drv_i`. A 1 on an enable pulls the line low, and there is no way to drive a line high.
- R8: Arbitration is lost when SCL rises while `start_o` is 1, `sda_drv_i` is 0 (releasing) and SDA is low. When `sda_drv_i` is 1 or SDA is high at that edge, there is no loss. The loss sets `arb_lost_o`.
- R9: While `arb_lost_o` is 1, both output enables are 0 whatever the drive inputs are. A Stop clears `arb_lost_o`.
- R10: `arb_stage_o` is 0 for a loss before the first `byte_done_i` after the most recent Start (address byte) and 1 for a loss after it (data byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable; low clears status |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| scl_drv_i | input | 1 | Local request to pull SCL low |
| sda_drv_i | input | 1 | Local request to pull SDA low |
| byte_done_i | input | 1 | One-cycle byte-complete pulse from the shifter |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Software clear of the interrupt flag |
| start_o | output | 1 | Sticky Start-seen bit |
| stop_o | output | 1 | Sticky Stop-seen bit |
| bus_free_o | output | 1 | Bus may be claimed |
| irq_flag_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Interrupt request (flag AND enable) |
| arb_lost_o | output | 1 | Arbitration lost since the last Stop |
| arb_stage_o | output | 1 | Stage of the loss: 0 address, 1 data |
| scl_oe_o | output | 1 | Open-drain pull-low enable for SCL |
| sda_oe_o | output | 1 | Open-drain pull-low enable for SDA |

## Verification
The bench sweeps all four pairs of drive inputs, with and without an arbitration loss. A gating mistake would show up there as an enable that stays high after a loss, or one that goes high without a request. The four combinations of release/drive and SDA level are tried at an SCL rise in both the address stage and the data stage. A design that checked arbitration while it was driving low, or that latched the wrong stage, fails there. Repeated Starts, SDA toggling while SCL is low, and a flag clear in the same cycle as a byte pulse are also covered. A design that decoded conditions from the wrong edge, or let the clear take priority, would lose a status bit or an interrupt.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  typedef enum logic {
    STG_ADDR = 1'b0,
    STG_DATA = 1'b1
  } arb_stage_e;

  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;  // idle bus is high
      else         ff_q <= {ff_q[STAGES-2:0], raw_i[l]};
    end
    assign sync_o[l] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  logic scl_hi;
  assign scl_hi     = scl_i & scl_q;
  assign start_o    = en_i & scl_hi & sda_q & ~sda_i;
  assign stop_o     = en_i & scl_hi & ~sda_q & sda_i;
  assign scl_rise_o = en_i & scl_i & ~scl_q;

  // R5
  scl_low_no_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_i |-> !(start_o || stop_o));
endmodule

// File: rtl/i2c_bus_status.sv
module i2c_bus_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic byte_done_i,
  input  logic irq_clr_i,
  output logic s_o,
  output logic p_o,
  output logic data_stage_o,
  output logic irq_flag_o
);
  logic s_q, p_q, data_q, irq_q;
  logic irq_set;

  assign irq_set = start_det_i | stop_det_i | (en_i & byte_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q    <= 1'b0;
      p_q    <= 1'b0;
      data_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (!en_i) begin
        s_q    <= 1'b0;
        p_q    <= 1'b0;
        data_q <= 1'b0;
      end else if (start_det_i) begin
        s_q    <= 1'b1;
        p_q    <= 1'b0;
        data_q <= 1'b0;
      end else if (stop_det_i) begin
        s_q    <= 1'b0;
        p_q    <= 1'b1;
        data_q <= 1'b0;
      end else if (byte_done_i && s_q) begin
        data_q <= 1'b1;
      end
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign s_o          = s_q;
  assign p_o          = p_q;
  assign data_stage_o = data_q;
  assign irq_flag_o   = irq_q;

  // R1
  disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!s_q && !p_q));
  // R2
  start_sets_s_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i |=> (s_q && !p_q && !data_q));
  // R3
  stop_sets_p_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det_i && !start_det_i) |=> (p_q && !s_q));
  // R2
  sp_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({s_q, p_q}));
  // R6
  irq_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det_i || stop_det_i) |=> irq_q);
endmodule

// File: rtl/i2c_arb_check.sv
module i2c_arb_check
  import i2c_mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       busy_i,
  input  logic       scl_rise_i,
  input  logic       sda_i,
  input  logic       sda_drv_i,
  input  logic       stop_det_i,
  input  logic       data_stage_i,
  output logic       lost_o,
  output arb_stage_e stage_o
);
  logic       lost_q;
  arb_stage_e stage_q;
  logic       mismatch;

  // only checked while releasing SDA, i.e. expecting high
  assign mismatch = scl_rise_i & busy_i & ~sda_drv_i & ~sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lost_q  <= 1'b0;
      stage_q <= STG_ADDR;
    end else if (!en_i || stop_det_i) begin
      lost_q  <= 1'b0;
    end else if (mismatch && !lost_q) begin
      lost_q  <= 1'b1;
      stage_q <= data_stage_i ? STG_DATA : STG_ADDR;
    end
  end

  assign lost_o  = lost_q;
  assign stage_o = stage_q;

  // R8
  driving_low_no_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lost_q && sda_drv_i) |=> !lost_q);
  // R9
  stop_clears_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> !lost_q);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic scl_drv_i,
  input  logic sda_drv_i,
  input  logic byte_done_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  output logic start_o,
  output logic stop_o,
  output logic bus_free_o,
  output logic irq_flag_o,
  output logic irq_o,
  output logic arb_lost_o,
  output logic arb_stage_o,
  output logic scl_oe_o,
  output logic sda_oe_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw, synced;
  logic start_det, stop_det, scl_rise;
  logic s, p, data_stage, lost;
  arb_stage_e stage;

  assign raw[LINE_SCL] = scl_i;
  assign raw[LINE_SDA] = sda_i;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(NLINES)) i_sync (
    .clk_i, .rst_ni, .raw_i(raw), .sync_o(synced)
  );

  i2c_cond_detect i_det (
    .clk_i, .rst_ni, .en_i,
    .scl_i(synced[LINE_SCL]), .sda_i(synced[LINE_SDA]),
    .start_o(start_det), .stop_o(stop_det), .scl_rise_o(scl_rise)
  );

  i2c_bus_status i_stat (
    .clk_i, .rst_ni, .en_i,
    .start_det_i(start_det), .stop_det_i(stop_det),
    .byte_done_i, .irq_clr_i,
    .s_o(s), .p_o(p), .data_stage_o(data_stage), .irq_flag_o
  );

  i2c_arb_check i_arb (
    .clk_i, .rst_ni, .en_i,
    .busy_i(s), .scl_rise_i(scl_rise), .sda_i(synced[LINE_SDA]),
    .sda_drv_i, .stop_det_i(stop_det), .data_stage_i(data_stage),
    .lost_o(lost), .stage_o(stage)
  );

  assign start_o     = s;
  assign stop_o      = p;
  assign bus_free_o  = p | (~s & ~p);
  assign irq_o       = irq_flag_o & irq_en_i;
  assign arb_lost_o  = lost;
  assign arb_stage_o = (stage == STG_DATA);
  assign scl_oe_o    = scl_drv_i & en_i & ~lost;
  assign sda_oe_o    = sda_drv_i & en_i & ~lost;

  // R9
  release_on_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> (!scl_oe_o && !sda_oe_o));
  // R7
  open_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o || scl_drv_i) && (!sda_oe_o || sda_drv_i));
  // R4
  busy_not_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !bus_free_o);
endmodule

// File: tb/test_i2c_bus_monitor.sv
module test_i2c_bus_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en, scl, sda, scl_drv, sda_drv, byte_done, irq_en, irq_clr;
  logic start_s, stop_s, bus_free, irq_flag, irq, arb_lost, arb_stage, scl_oe, sda_oe;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_bus_monitor i_i2c_bus_monitor (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
    .scl_drv_i(scl_drv), .sda_drv_i(sda_drv), .byte_done_i(byte_done),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .start_o(start_s), .stop_o(stop_s), .bus_free_o(bus_free),
    .irq_flag_o(irq_flag), .irq_o(irq), .arb_lost_o(arb_lost),
    .arb_stage_o(arb_stage), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_scl(input logic v); scl = v; settle(); endtask
  task automatic set_sda(input logic v); sda = v; settle(); endtask

  task automatic do_start();  // from SCL low or idle
    set_sda(1'b1); set_scl(1'b1); set_sda(1'b0); set_scl(1'b0);
  endtask

  task automatic do_stop();
    sda_drv = 1'b1;
    set_scl(1'b0); set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
  endtask

  task automatic pulse_byte();
    byte_done = 1'b1; @(negedge clk); byte_done = 1'b0; @(negedge clk);
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    en = 1'b1; scl = 1'b1; sda = 1'b1; scl_drv = 1'b0; sda_drv = 1'b0;
    byte_done = 1'b0; irq_en = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset S/P/free", {start_s, stop_s, bus_free}, 8'b001);
    rst_n = 1'b1;
    settle();
    check("R1 idle after reset", {start_s, stop_s, bus_free, irq_flag}, 8'b0010);

    // R5: SDA toggles with SCL low
    set_scl(1'b0); set_sda(1'b0); set_sda(1'b1);
    check("R5 no condition when SCL low", {start_s, stop_s, irq_flag}, 8'b000);

    // R2 Start with latency 3 edges
    set_scl(1'b1);
    sda = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R2 not yet after 2 edges", start_s, 1'b0);
    @(negedge clk);
    check("R2 start after 3 edges", {start_s, stop_s, bus_free}, 8'b100);
    check("R6 irq on start", irq_flag, 1'b1);
    check("R6 irq_o gated off", irq, 1'b0);
    clr_irq();
    check("R6 cleared", irq_flag, 1'b0);
    set_scl(1'b0);

    // R6 byte pulse, set wins over clear
    byte_done = 1'b1; irq_clr = 1'b1; @(negedge clk);
    byte_done = 1'b0; irq_clr = 1'b0; @(negedge clk);
    check("R6 set beats clear", irq_flag, 1'b1);
    clr_irq();

    // R4 repeated start returns to address stage
    do_start();
    check("R4 repeated start S/free", {start_s, stop_s, bus_free}, 8'b100);
    set_sda(1'b0); sda_drv = 1'b0; set_scl(1'b1);
    check("R10 address-stage loss", {arb_lost, arb_stage}, 8'b10);

    // R6/R3 Stop while busy raises irq
    clr_irq(); irq_en = 1'b1;
    do_stop();
    check("R3 stop S/P/free", {start_s, stop_s, bus_free}, 8'b011);
    check("R6 irq_o on stop", irq, 1'b1);
    check("R9 stop clears loss", arb_lost, 1'b0);
    clr_irq(); irq_en = 1'b0;

    // R8/R10 sweep: stage x drive x level
    for (int st = 0; st < 2; st++) begin
      for (int drv = 0; drv < 2; drv++) begin
        for (int lvl = 0; lvl < 2; lvl++) begin
          sda_drv = 1'b1;
          do_start();
          if (st == 1) pulse_byte();
          set_sda(lvl[0]);
          sda_drv = drv[0];
          set_scl(1'b1);
          check($sformatf("R8 loss st%0d drv%0d lvl%0d", st, drv, lvl),
                arb_lost, (drv == 0 && lvl == 0));
          if (drv == 0 && lvl == 0)
            check($sformatf("R10 stage st%0d", st), arb_stage, st[0]);
          // R7/R9 enable gating over all drive pairs
          for (int d = 0; d < 4; d++) begin
            scl_drv = d[0]; sda_drv = d[1]; #1;
            check($sformatf("R7 oe d%0d lost%0d", d, (drv == 0 && lvl == 0)),
                  {scl_oe, sda_oe},
                  (drv == 0 && lvl == 0) ? 8'b00 : {6'b0, d[0], d[1]});
          end
          scl_drv = 1'b0;
          do_stop();
          check("R9 lines usable after stop", arb_lost, 1'b0);
        end
      end
    end

    // R1 disable clears status and blocks events
    do_start();
    check("R2 busy before disable", start_s, 1'b1);
    en = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1; @(negedge clk); @(negedge clk);
    check("R1 disable clears", {start_s, stop_s, bus_free}, 8'b001);
    check("R7 oe off when disabled", {scl_oe, sda_oe}, 8'b00);
    clr_irq();
    set_sda(1'b1); set_scl(1'b1); set_sda(1'b0);
    check("R1 start ignored when disabled", {start_s, irq_flag}, 8'b00);
    en = 1'b1; settle();
    check("R7 oe back on", {scl_oe, sda_oe}, 8'b11);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule